// File: doc/BRIEF.md
# Shape-Qualified Spectral Trigger Decision Pipeline

This block takes the final decision for one ADC channel of a shape-based trigger. Every clock it captures one sample into a 16-deep window. It looks at the three oldest entries of that window. The two oldest must sit on the pedestal. The third-oldest must climb above it, which marks a one-bin rising edge. That rising sample is also the pulse amplitude, and a veto threshold decides whether the amplitude is large enough to enable the trigger.

A spectral transform outside this block reports a vector of per-cycle sub-trigger flags. The block counts the set flags into an occupancy value. The amplitude-derived enable is delayed by a fixed number of cycles so that it meets that occupancy result in the same cycle. When both agree, a one-cycle sub-trigger is produced. One cycle later it is combined with the neighbouring engines' flags into the final trigger. An external inhibit suppresses both outputs.

A small state machine guards start-up. In state FILL the window still holds reset contents, so no qualification is allowed. The transition FILL→RUN is taken once the window has been completely refilled with captured samples. RUN is held until the next reset, which is the only transition back to FILL.

Top module: `shape_trig_decider`

## Requirements
- R1: While reset is asserted and right after it, `sub_trig` and `final_trig` are 0, the window is cleared and the state is FILL.
- R2: Qualification is suppressed until 16 samples have been captured since reset. The state moves FILL→RUN on the edge that captures the 16th sample.
- R3: Let e be the edge that captures a sample. Relative to it, the shape is accepted only when all three of these hold: the sample from e-2 is within `ped_tol` of `pedestal` (inclusive), the sample from e-1 is within `ped_tol` of `pedestal` (inclusive), and the sample from e exceeds `pedestal + ped_tol`.
- R4: The rising sample is the amplitude. The enable is granted only if amplitude >= `veto_thr`; a smaller amplitude vetoes the event.
- R5: The occupancy is the number of set bits in `sub_flags` as captured 27 edges after the rising sample. The occupancy condition holds when this count is >= `occ_min`.
- R6: `sub_trig` is high for exactly one cycle, right after the edge 29 edges after the rising sample's capture edge. Flags captured one edge earlier or later than the edge R5 names do not contribute.
- R7: `final_trig` is high for one cycle, one edge after `sub_trig`, if at least one bit of `nbr_flags` is set at that edge. Otherwise it stays 0.
- R8: `inhibit` high at the edge that would set `sub_trig` or `final_trig` keeps that output at 0.
- R9: Both outputs stay 0 in every cycle not covered by R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_in | input | SAMPLE_W | ADC sample captured on each edge |
| pedestal | input | SAMPLE_W | Pedestal reference level |
| ped_tol | input | SAMPLE_W | Allowed deviation from the pedestal |
| veto_thr | input | SAMPLE_W | Minimum amplitude that enables a trigger |
| occ_min | input | OCC_W | Minimum count of set sub-trigger flags |
| sub_flags | input | N_FLAGS | Per-cycle sub-trigger flags from the transform |
| nbr_flags | input | N_NBR | Sub-trigger flags of neighbouring engines |
| inhibit | input | 1 | Blocks both outputs while high |
| sub_trig | output | 1 | Local sub-trigger pulse |
| final_trig | output | 1 | Final trigger pulse |

## Verification
The case that is hardest to reach from the ports is a qualifying shape that appears while the window still holds reset contents. Every realistic pedestal keeps the cleared entries from ever looking like a baseline. To get there, the stimulus lowers the pedestal and tolerance to zero in a dedicated phase, so the reset zeros pass as pedestal bins. It then drives a large sample on the very first post-reset edge and presents full flags at the matching cycle, and the R2 gate must swallow that event. The flag path is also stepped one edge early and one edge late around the aligned cycle, which shows that only the exact coincidence fires.

// File: rtl/stp_pkg.sv
package stp_pkg;

    typedef enum logic [0:0] {
        ST_FILL = 1'b0,
        ST_RUN  = 1'b1
    } fill_state_e;

endpackage

// File: rtl/stp_window.sv
module stp_window #(
    parameter int SAMPLE_W = 12,
    parameter int DEPTH    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    output logic [SAMPLE_W-1:0] tap_oldest,
    output logic [SAMPLE_W-1:0] tap_second,
    output logic [SAMPLE_W-1:0] tap_rise
);
    // position 0 holds the newest sample, position DEPTH-1 the oldest
    logic [SAMPLE_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cell_q[0] <= '0;
        end else begin
            cell_q[0] <= sample_in;
        end
    end

    generate
        for (genvar g = 1; g < DEPTH; g++) begin : g_cell
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cell_q[g] <= '0;
                end else begin
                    cell_q[g] <= cell_q[g-1];
                end
            end
        end
    endgenerate

    assign tap_oldest = cell_q[DEPTH-1];
    assign tap_second = cell_q[DEPTH-2];
    assign tap_rise   = cell_q[DEPTH-3];

endmodule

// File: rtl/stp_shape_qual.sv
module stp_shape_qual #(
    parameter int SAMPLE_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] bin_oldest,
    input  logic [SAMPLE_W-1:0] bin_second,
    input  logic [SAMPLE_W-1:0] bin_rise,
    input  logic [SAMPLE_W-1:0] pedestal,
    input  logic [SAMPLE_W-1:0] ped_tol,
    input  logic [SAMPLE_W-1:0] veto_thr,
    input  logic                running,
    output logic                ena_a
);
    localparam int EXT_W = SAMPLE_W + 1;

    function automatic logic near_ped(
        input logic [SAMPLE_W-1:0] x,
        input logic [SAMPLE_W-1:0] ped,
        input logic [SAMPLE_W-1:0] tol
    );
        logic [SAMPLE_W-1:0] gap;
        gap = (x >= ped) ? (x - ped) : (ped - x);
        return gap <= tol;
    endfunction

    logic [EXT_W-1:0] rise_floor;
    logic             near_old_c, near_sec_c, rise_c, big_c;

    always_comb begin
        rise_floor = {1'b0, pedestal} + {1'b0, ped_tol};
        near_old_c = near_ped(bin_oldest, pedestal, ped_tol);
        near_sec_c = near_ped(bin_second, pedestal, ped_tol);
        rise_c     = {1'b0, bin_rise} > rise_floor;
        big_c      = bin_rise >= veto_thr;
    end

    // stage 1: per-bin compares, stage 2: shape AND, stage 3: veto gate
    logic s1_near_old, s1_near_sec, s1_rise, s1_big, s1_run;
    logic s2_shape, s2_big;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_near_old <= 1'b0;
            s1_near_sec <= 1'b0;
            s1_rise     <= 1'b0;
            s1_big      <= 1'b0;
            s1_run      <= 1'b0;
            s2_shape    <= 1'b0;
            s2_big      <= 1'b0;
            ena_a       <= 1'b0;
        end else begin
            s1_near_old <= near_old_c;
            s1_near_sec <= near_sec_c;
            s1_rise     <= rise_c;
            s1_big      <= big_c;
            s1_run      <= running;
            s2_shape    <= s1_near_old & s1_near_sec & s1_rise & s1_run;
            s2_big      <= s1_big;
            ena_a       <= s2_shape & s2_big;
        end
    end

endmodule

// File: rtl/stp_delay.sv
module stp_delay #(
    parameter int DLY = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    generate
        if (DLY == 0) begin : g_wire
            assign dout = din;
        end else begin : g_pipe
            logic [DLY-1:0] pipe_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pipe_q <= '0;
                end else begin
                    pipe_q[0] <= din;
                    for (int i = 1; i < DLY; i++) begin
                        pipe_q[i] <= pipe_q[i-1];
                    end
                end
            end
            assign dout = pipe_q[DLY-1];
        end
    endgenerate

endmodule

// File: rtl/stp_occupancy.sv
module stp_occupancy #(
    parameter int N_FLAGS = 16,
    parameter int OCC_W   = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAGS-1:0] flags,
    input  logic [OCC_W-1:0]   occ_min,
    output logic               occ_ok
);
    logic [OCC_W-1:0] pop_c;
    logic [OCC_W-1:0] cnt_q;

    always_comb begin
        pop_c = '0;
        for (int i = 0; i < N_FLAGS; i++) begin
            pop_c = pop_c + OCC_W'(flags[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            occ_ok <= 1'b0;
        end else begin
            cnt_q  <= pop_c;
            occ_ok <= (cnt_q >= occ_min);
        end
    end

endmodule

// File: rtl/shape_trig_decider.sv
module shape_trig_decider #(
    parameter int SAMPLE_W  = 12,
    parameter int DEPTH     = 16,
    parameter int N_FLAGS   = 16,
    parameter int N_NBR     = 4,
    parameter int ALIGN_DLY = 12,
    parameter int OCC_W     = $clog2(N_FLAGS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SAMPLE_W-1:0] sample_in,
    input  logic [SAMPLE_W-1:0] pedestal,
    input  logic [SAMPLE_W-1:0] ped_tol,
    input  logic [SAMPLE_W-1:0] veto_thr,
    input  logic [OCC_W-1:0]    occ_min,
    input  logic [N_FLAGS-1:0]  sub_flags,
    input  logic [N_NBR-1:0]    nbr_flags,
    input  logic                inhibit,
    output logic                sub_trig,
    output logic                final_trig
);
    import stp_pkg::*;

    localparam int                FILL_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [FILL_W-1:0] FILL_LAST = FILL_W'(DEPTH - 1);

    fill_state_e       state_q, state_d;
    logic [FILL_W-1:0] fill_cnt_q;
    logic              running;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_FILL;
            fill_cnt_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FILL) begin
                fill_cnt_q <= fill_cnt_q + 1'b1;
            end
        end
    end

    // transitions: FILL->RUN after the window is refilled, RUN held
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL: if (fill_cnt_q == FILL_LAST) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_FILL;
        endcase
    end

    // state outputs
    always_comb begin
        running = (state_q == ST_RUN);
    end

    logic [SAMPLE_W-1:0] tap_oldest, tap_second, tap_rise;
    logic                ena_a, ena_aligned, occ_ok;

    stp_window #(
        .SAMPLE_W (SAMPLE_W),
        .DEPTH    (DEPTH)
    ) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_in  (sample_in),
        .tap_oldest (tap_oldest),
        .tap_second (tap_second),
        .tap_rise   (tap_rise)
    );

    stp_shape_qual #(
        .SAMPLE_W (SAMPLE_W)
    ) u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .bin_oldest (tap_oldest),
        .bin_second (tap_second),
        .bin_rise   (tap_rise),
        .pedestal   (pedestal),
        .ped_tol    (ped_tol),
        .veto_thr   (veto_thr),
        .running    (running),
        .ena_a      (ena_a)
    );

    stp_delay #(
        .DLY (ALIGN_DLY)
    ) u_align (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ena_a),
        .dout  (ena_aligned)
    );

    stp_occupancy #(
        .N_FLAGS (N_FLAGS),
        .OCC_W   (OCC_W)
    ) u_occ (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (sub_flags),
        .occ_min (occ_min),
        .occ_ok  (occ_ok)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sub_trig   <= 1'b0;
            final_trig <= 1'b0;
        end else begin
            sub_trig   <= ena_aligned & occ_ok & ~inhibit;
            final_trig <= sub_trig & (|nbr_flags) & ~inhibit;
        end
    end

endmodule

// File: rtl/stp_checker.sv
module stp_checker (
    input logic clk,
    input logic rst_n,
    input logic sub_trig,
    input logic final_trig,
    input logic inhibit,
    input logic running,
    input logic ena_a
);
    p_sub_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sub_trig |=> !sub_trig)
        else $error("sub_trig held longer than one cycle");

    p_final_after_sub_r7: assert property (@(posedge clk) disable iff (!rst_n)
        final_trig |-> $past(sub_trig))
        else $error("final_trig without preceding sub_trig");

    p_inhibit_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inhibit) |-> (!sub_trig && !final_trig))
        else $error("output raised under inhibit");

    p_fill_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !ena_a)
        else $error("enable produced before window refilled");

    p_rise_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ena_a |=> !ena_a)
        else $error("shape enable on consecutive cycles");

endmodule

bind shape_trig_decider stp_checker u_stp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sub_trig   (sub_trig),
    .final_trig (final_trig),
    .inhibit    (inhibit),
    .running    (running),
    .ena_a      (ena_a)
);

// File: tb/test_shape_trig_decider.sv
module test_shape_trig_decider;
    localparam int SW    = 12;
    localparam int NF    = 16;
    localparam int NN    = 4;
    localparam int OW    = 5;
    localparam int MAXE  = 1000;
    localparam int PH_B  = 100;
    localparam int END_E = 860;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [SW-1:0] sample_in = '0;
    logic [SW-1:0] pedestal = '0;
    logic [SW-1:0] ped_tol = '0;
    logic [SW-1:0] veto_thr = '0;
    logic [OW-1:0] occ_min = '0;
    logic [NF-1:0] sub_flags = '0;
    logic [NN-1:0] nbr_flags = '0;
    logic          inhibit = 1'b0;
    logic          sub_trig, final_trig;

    shape_trig_decider i_shape_trig_decider (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_in  (sample_in),
        .pedestal   (pedestal),
        .ped_tol    (ped_tol),
        .veto_thr   (veto_thr),
        .occ_min    (occ_min),
        .sub_flags  (sub_flags),
        .nbr_flags  (nbr_flags),
        .inhibit    (inhibit),
        .sub_trig   (sub_trig),
        .final_trig (final_trig)
    );

    always #4 clk = ~clk;

    int edge_n = 0;
    always @(posedge clk) edge_n <= edge_n + 1;

    // stimulus per edge index
    logic [SW-1:0] smp [MAXE];
    logic [NF-1:0] flg [MAXE];
    logic [NN-1:0] nbr [MAXE];
    bit            inh [MAXE];
    bit            rstv [MAXE];

    typedef struct {
        int    at;
        bit    sub;
        bit    fin;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    exp_t cur;

    int n_tests = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    task automatic chk(input logic act, input logic expv, input string tag, input string what);
        n_tests++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s %s at edge %0d: actual %0b expected %0b", tag, what, edge_n, act, expv);
        end
    endtask

    task automatic push_exp(input int at, input bit s, input bit f, input string tag);
        exp_t e;
        e.at = at; e.sub = s; e.fin = f; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // driver side: one pulse with shape bins, flags, neighbours, inhibit
    task automatic put_event(input int e0, input int ped, input int b15, input int b14,
                             input int amp, input int nset, input int foff, input bit nb,
                             input bit inh_s, input bit inh_f, input bit es, input bit ef,
                             input string tag);
        smp[e0-2] = SW'(b15);
        smp[e0-1] = SW'(b14);
        smp[e0]   = SW'(amp);
        for (int i = 1; i <= 11; i++) smp[e0+i] = SW'(ped + ((amp - ped) >> i));
        flg[e0+foff] = (nset >= NF) ? '1 : NF'((1 << nset) - 1);
        nbr[e0+30]   = nb ? NN'(4'b0100) : '0;
        inh[e0+29]   = inh_s;
        inh[e0+30]   = inh_f;
        push_exp(e0 + 29, es, 1'b0, tag);
        push_exp(e0 + 30, 1'b0, ef, tag);
    endtask

    // monitor + driver, away from the active edge
    always @(negedge clk) begin
        if (!finished) begin
            if (exp_q.size() > 0 && exp_q[0].at == edge_n) begin
                cur = exp_q.pop_front();
                chk(sub_trig, cur.sub, cur.tag, "sub_trig");
                chk(final_trig, cur.fin, cur.tag, "final_trig");
            end else if (rst_n) begin
                chk(sub_trig, 1'b0, "R9", "quiet sub_trig");
                chk(final_trig, 1'b0, "R9", "quiet final_trig");
            end
            if (edge_n + 1 < MAXE) begin
                rst_n     = rstv[edge_n+1];
                sample_in = smp[edge_n+1];
                sub_flags = flg[edge_n+1];
                nbr_flags = nbr[edge_n+1];
                inhibit   = inh[edge_n+1];
                if (edge_n + 1 < PH_B) begin
                    pedestal = SW'(0);  ped_tol = SW'(0);
                    veto_thr = SW'(50); occ_min = OW'(1);
                end else begin
                    pedestal = SW'(40);  ped_tol = SW'(2);
                    veto_thr = SW'(100); occ_min = OW'(3);
                end
            end
        end
    end

    initial begin
        for (int k = 0; k < MAXE; k++) begin
            smp[k]  = (k < PH_B) ? SW'(0) : SW'(40);
            flg[k]  = '0;
            nbr[k]  = '0;
            inh[k]  = 1'b0;
            rstv[k] = !((k <= 3) || (k >= PH_B && k <= PH_B + 2));
        end
        // R1: outputs low under reset
        push_exp(1, 1'b0, 1'b0, "R1");
        push_exp(2, 1'b0, 1'b0, "R1");
        // R2: first capture edge is 4; reset zeros pose as pedestal bins
        smp[4]  = SW'(100);
        flg[31] = '1;
        push_exp(33, 1'b0, 1'b0, "R2");
        push_exp(34, 1'b0, 1'b0, "R2");
        // phase A positive event once running (pedestal 0, veto 50)
        put_event(44, 0, 0, 0, 100, 1, 27, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R2,R6");
        // R1 again across the second reset
        push_exp(PH_B + 1, 1'b0, 1'b0, "R1");
        push_exp(PH_B + 2, 1'b0, 1'b0, "R1");
        // phase B: pedestal 40, tolerance 2, veto 100, occ_min 3
        put_event(150, 40, 40, 40, 140,  3, 27, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R6,R7");
        put_event(210, 40, 38, 42, 140,  3, 27, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R3");
        put_event(270, 40, 37, 40, 140,  3, 27, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
        put_event(330, 40, 40, 40,  99,  3, 27, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R4");
        put_event(390, 40, 40, 40, 100,  3, 27, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R4");
        put_event(450, 40, 40, 40, 140,  2, 27, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        put_event(510, 40, 40, 40, 140, 16, 26, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        put_event(570, 40, 40, 40, 140, 16, 28, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        put_event(630, 40, 40, 40, 140,  3, 27, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, "R7");
        put_event(690, 40, 40, 40, 140,  3, 27, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8");
        put_event(750, 40, 40, 40, 140,  3, 27, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, "R8");
        put_event(810, 40, 40, 40, 140, 16, 27, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R5");

        wait (edge_n >= END_E);
        @(negedge clk);
        finished = 1'b1;
        if (exp_q.size() != 0) begin
            n_tests++;
            n_fail++;
            $display("FAIL R9 scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL R9 watchdog: actual edge %0d expected end by %0d", edge_n, END_E);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule